// File: doc/BRIEF.md
# Saturating Packed Shift-Left Unit

This block takes a 64-bit word of packed integer elements and shifts every element left by its own amount. Any result that does not fit in the element is replaced by the nearest limit of the element's range. The element width is chosen per operation as 8, 16, 32 or 64 bits. Elements are read as two's-complement or as unsigned, under a select. The shift amount for each element comes from one of three places: the matching element of a second packed word, one scalar broadcast to every element, or a short immediate. A per-element enable mask limits which elements are computed. Disabled elements return the element's previous destination value.

Overflow is found without any wider intermediate. The shifted value is shifted back right by the same amount, using an arithmetic shift for signed data and a logical shift for unsigned data. If the value that comes back differs from the input, the element has overflowed. This works at 64-bit element width with nothing wider than 64 bits. Each result carries a per-element saturation vector. A sticky saturation flag gathers saturation events until it is cleared by a dedicated input.

The operation enters through a valid/ready port and leaves one cycle later through a valid/ready port. The result register holds steady while the consumer stalls. The input is refused (`in_ready` low) while an unconsumed result would be overwritten. A new operation may be accepted in the same cycle that the old result is taken.

Top module: `vsat_shl_unit`

## Requirements
- R1: `ew_sel` encodes 0=8, 1=16, 2=32 and 3=64-bit elements, and element i occupies bits [i*w +: w]. An enabled element whose shifted value fits is output as the input element shifted left by its effective amount.
- R2: With `is_signed`=1, an overflowing element becomes 2^(w-1)-1 if its input was non-negative, or -2^(w-1) (sign bit only) if its input was negative.
- R3: With `is_signed`=0, the element is treated as unsigned, and an overflowing element becomes all ones.
- R4: `shamt_src` selects the amount source. 0 takes element i of `shamt_vec` at the current width, 1 takes `shamt_scalar` for every element, and 2 or 3 take the zero-extended 5-bit `shamt_imm`.
- R5: Only the low log2(w) bits of the selected amount are used, and all higher bits have no effect.
- R6: Bit i of `elem_mask` enables element i. A disabled element outputs the matching element of `old_data` and never saturates. Mask bits at or above 64/w are ignored.
- R7: Bit i of `out_sat` is 1 exactly when enabled element i saturated. Bits at or above 64/w are 0.
- R8: `sat_sticky` becomes 1 on the edge that accepts an operation with any saturated element, and stays 1 until `sat_clear` is high at an edge. When a clear and such an acceptance occur at the same edge, the flag ends up 1. A clear with no new saturation makes it 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted operation appears with `out_valid` high after the next edge. While `out_valid` is high and `out_ready` is low, `out_data` and `out_sat` hold. All state resets to 0 on an active-low `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_data | input | 64 | Packed source elements |
| old_data | input | 64 | Previous destination, used for disabled elements |
| shamt_vec | input | 64 | Packed per-element shift amounts |
| shamt_scalar | input | 64 | Broadcast shift amount |
| shamt_imm | input | 5 | Immediate shift amount |
| shamt_src | input | 2 | Amount source select |
| ew_sel | input | 2 | Element width select |
| is_signed | input | 1 | 1 = two's-complement, 0 = unsigned |
| elem_mask | input | 8 | Per-element enable |
| sat_clear | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 64 | Packed result |
| out_sat | output | 8 | Per-element saturation |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Two events can meet at one clock edge. In the first, `sat_clear` arrives on the same edge that accepts a saturating operation, and the flag must come out set. The bench drives clear pulses both alone and together with saturating and non-saturating operations, and compares the flag against a software copy of the set-over-clear rule. In the second, a stalled result is taken on the same edge that a new operation is accepted. The bench holds `out_ready` low while a second operation waits. It checks that `in_ready` stays low and the old result stays put, then releases the stall and expects the second result on the next cycle.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    SRC_VEC     = 2'd0,
    SRC_SCALAR  = 2'd1,
    SRC_IMM     = 2'd2,
    SRC_IMM_ALT = 2'd3
  } src_e;
endpackage

// File: rtl/vsat_lane.sv
module vsat_lane #(
  parameter int W   = 8,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] sh,
  input  logic           is_signed,
  output logic [W-1:0]   res,
  output logic           sat
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] shl;
  logic [W-1:0] back_arith;
  logic [W-1:0] back_logic;
  logic [W-1:0] back;

  always_comb begin
    shl        = a << sh;
    back_arith = $signed(shl) >>> sh;
    back_logic = shl >> sh;
    back       = is_signed ? back_arith : back_logic;
    sat        = (back != a);
    if (!sat)
      res = shl;
    else if (!is_signed)
      res = {W{1'b1}};
    else
      res = a[W-1] ? SMIN : SMAX;
  end

  always_comb begin
    if (sat && is_signed)
      assert_sign_kept_R2: assert (res[W-1] == a[W-1]);
    if (sh == '0)
      assert_zero_shift_fits_R1: assert (!sat && res == a);
  end
endmodule

// File: rtl/vsat_width_slice.sv
module vsat_width_slice
  import vsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int W      = 8,
  parameter int IMM_W  = 5,
  localparam int NE    = DATA_W / W,
  localparam int SHW   = $clog2(W),
  localparam int EXT   = (IMM_W > SHW) ? IMM_W : SHW
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] shamt_vec,
  input  logic [DATA_W-1:0] shamt_scalar,
  input  logic [IMM_W-1:0]  shamt_imm,
  input  src_e              src,
  input  logic              is_signed,
  input  logic [NE-1:0]     mask,
  output logic [DATA_W-1:0] res,
  output logic [NE-1:0]     sat
);
  logic [EXT-1:0] imm_ext;
  assign imm_ext = EXT'(shamt_imm);

  for (genvar i = 0; i < NE; i++) begin : g_lane
    logic [SHW-1:0] sh;
    logic [W-1:0]   lane_res;
    logic           lane_sat;

    always_comb begin
      unique case (src)
        SRC_VEC:    sh = shamt_vec[i*W +: SHW];
        SRC_SCALAR: sh = shamt_scalar[SHW-1:0];
        default:    sh = imm_ext[SHW-1:0];
      endcase
    end

    vsat_lane #(.W(W)) u_lane (
      .a         (in_data[i*W +: W]),
      .sh        (sh),
      .is_signed (is_signed),
      .res       (lane_res),
      .sat       (lane_sat)
    );

    assign res[i*W +: W] = mask[i] ? lane_res : old_data[i*W +: W];
    assign sat[i]        = mask[i] & lane_sat;
  end
endmodule

// File: rtl/vsat_shl_unit.sv
module vsat_shl_unit
  import vsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_EW = 8,
  parameter int IMM_W  = 5,
  localparam int LANES = DATA_W / MIN_EW,
  localparam int N_EW  = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] shamt_vec,
  input  logic [DATA_W-1:0] shamt_scalar,
  input  logic [IMM_W-1:0]  shamt_imm,
  input  logic [1:0]        shamt_src,
  input  logic [1:0]        ew_sel,
  input  logic              is_signed,
  input  logic [LANES-1:0]  elem_mask,
  input  logic              sat_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_sat,
  output logic              sat_sticky
);
  logic [DATA_W-1:0] slice_res [N_EW];
  logic [LANES-1:0]  slice_sat [N_EW];
  src_e              src;

  assign src = src_e'(shamt_src);

  for (genvar k = 0; k < N_EW; k++) begin : g_width
    localparam int W  = MIN_EW << k;
    localparam int NE = DATA_W / W;
    logic [NE-1:0] sat_w;

    vsat_width_slice #(.DATA_W(DATA_W), .W(W), .IMM_W(IMM_W)) u_slice (
      .in_data      (in_data),
      .old_data     (old_data),
      .shamt_vec    (shamt_vec),
      .shamt_scalar (shamt_scalar),
      .shamt_imm    (shamt_imm),
      .src          (src),
      .is_signed    (is_signed),
      .mask         (elem_mask[NE-1:0]),
      .res          (slice_res[k]),
      .sat          (sat_w)
    );
    assign slice_sat[k] = LANES'(sat_w);
  end

  logic [DATA_W-1:0] nxt_data;
  logic [LANES-1:0]  nxt_sat;
  logic              accept;

  assign nxt_data = slice_res[ew_sel];
  assign nxt_sat  = slice_sat[ew_sel];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sat    <= '0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= accept || (out_valid && !out_ready);
      sat_sticky <= (sat_sticky && !sat_clear) || (accept && (|nxt_sat));
      if (accept) begin
        out_data <= nxt_data;
        out_sat  <= nxt_sat;
      end
    end
  end

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (|nxt_sat)) |=> sat_sticky);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clear) |=> sat_sticky);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));

  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/vsat_shl_unit_bench.sv
`timescale 1ns/1ps
module vsat_shl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0, old_data = '0, shamt_vec = '0, shamt_scalar = '0;
  logic [4:0]  shamt_imm = '0;
  logic [1:0]  shamt_src = '0, ew_sel = '0;
  logic        is_signed = 1'b0;
  logic [7:0]  elem_mask = '0;
  logic        sat_clear = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_sat;
  logic        sat_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_sticky = 1'b0;

  always #10 clk = ~clk;

  vsat_shl_unit u_vsat_shl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .old_data(old_data), .shamt_vec(shamt_vec),
    .shamt_scalar(shamt_scalar), .shamt_imm(shamt_imm), .shamt_src(shamt_src),
    .ew_sel(ew_sel), .is_signed(is_signed), .elem_mask(elem_mask),
    .sat_clear(sat_clear), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat), .sat_sticky(sat_sticky)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // Arithmetic reference: {sat, value}
  function automatic logic [64:0] ref_elem(input logic [63:0] a, input int sh,
                                           input int w, input logic sgn);
    logic signed [129:0] av, pr, mx, mn;
    logic [63:0] mw;
    logic s;
    mw = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    av = 130'(a & mw);
    if (sgn && a[w-1]) av = av - (130'sd1 <<< w);
    pr = av <<< sh;
    if (sgn) begin
      mx = (130'sd1 <<< (w-1)) - 130'sd1;
      mn = -(130'sd1 <<< (w-1));
    end else begin
      mx = (130'sd1 <<< w) - 130'sd1;
      mn = '0;
    end
    s = 1'b0;
    if (pr > mx) begin s = 1'b1; pr = mx; end
    else if (pr < mn) begin s = 1'b1; pr = mn; end
    return {s, 64'(pr) & mw};
  endfunction

  task automatic compute(output logic [63:0] ed, output logic [7:0] es);
    int w, n;
    logic [63:0] mw;
    w  = 8 << ew_sel;
    n  = 64 / w;
    mw = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ed = '0;
    es = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, raw;
      logic [64:0] r;
      a = (in_data >> (i*w)) & mw;
      case (shamt_src)
        2'd0:    raw = (shamt_vec >> (i*w)) & mw;
        2'd1:    raw = shamt_scalar;
        default: raw = 64'(shamt_imm);
      endcase
      if (elem_mask[i]) begin
        r = ref_elem(a, int'(raw & 64'(w-1)), w, is_signed);
        ed |= r[63:0] << (i*w);
        es[i] = r[64];
      end else begin
        ed |= ((old_data >> (i*w)) & mw) << (i*w);
      end
    end
  endtask

  task automatic run_op(input logic [1:0] ew, input logic sgn, input logic [1:0] src,
                        input logic [63:0] d, input logic [63:0] od,
                        input logic [63:0] sv, input logic [63:0] ss,
                        input logic [4:0] imm, input logic [7:0] m,
                        input logic clr, input string tag);
    logic [63:0] ed;
    logic [7:0]  es;
    @(negedge clk);
    ew_sel = ew; is_signed = sgn; shamt_src = src; in_data = d; old_data = od;
    shamt_vec = sv; shamt_scalar = ss; shamt_imm = imm; elem_mask = m;
    sat_clear = clr; in_valid = 1'b1;
    compute(ed, es);
    exp_sticky = (exp_sticky && !clr) || (|es);
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
    chk(out_valid == 1'b1, {tag, " R9 out_valid"}, 64'(out_valid), 64'd1);
    chk(out_data == ed, {tag, " data"}, out_data, ed);
    chk(out_sat == es, {tag, " R7 sat"}, 64'(out_sat), 64'(es));
    chk(sat_sticky == exp_sticky, {tag, " R8 sticky"}, 64'(sat_sticky), 64'(exp_sticky));
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d, sv, ed1, ed2;
    logic [7:0]  es1, es2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(sat_sticky == 1'b0, "R8 reset sticky", 64'(sat_sticky), 64'd0);
    chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'd1);
    chk(out_data == '0, "R9 reset data", out_data, 64'd0);

    // Exhaustive 8-bit sweep: R1 R2 R3 R5 R6 via vector amounts
    for (int sg = 0; sg < 2; sg++)
      for (int v = 0; v < 256; v++)
        for (int s = 0; s < 8; s++) begin
          d = '0; sv = '0;
          for (int i = 0; i < 8; i++) begin
            d[i*8 +: 8]  = 8'(v + 29*i);
            sv[i*8 +: 8] = {5'($urandom), 3'(s + i)};
          end
          run_op(2'd0, 1'(sg), 2'd0, d, r64(), sv, '0, '0, 8'($urandom),
                 ($urandom % 8) == 0, "R1/R2/R3/R5/R6 e8");
        end

    // Wider elements with scalar/immediate sources: R4 R5 R6 R1
    for (int e = 1; e < 4; e++) begin
      int w;
      w = 8 << e;
      for (int s = 0; s < w; s++)
        for (int sg = 0; sg < 2; sg++)
          for (int k = 0; k < 8; k++) begin
            d = r64();
            if (k >= 4)
              for (int i = 0; i < 64 / w; i++)
                for (int b = 0; b < w; b++)
                  d[i*w + b] = (b < 2) ? d[i*w + b] : k[0];
            run_op(2'(e), 1'(sg), 2'(k % 4), d, r64(), r64(),
                   {r64()[63:6], 6'(s)}, 5'(s), 8'($urandom),
                   ($urandom % 8) == 0, "R1/R4/R5/R6 wide");
          end
    end

    // Sticky corners R8
    run_op(2'd0, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 64'd1, '0, 8'hFF, 1'b0, "R8 set");
    run_op(2'd0, 1'b0, 2'd1, 64'd0, '0, '0, 64'd1, '0, 8'hFF, 1'b0, "R8 hold");
    run_op(2'd0, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 64'd1, '0, 8'hFF, 1'b1, "R8 clear+set");
    run_op(2'd0, 1'b0, 2'd1, 64'd0, '0, '0, 64'd1, '0, 8'hFF, 1'b1, "R8 clear op");
    run_op(2'd0, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 64'd1, '0, 8'h00, 1'b0, "R6 masked no set");
    run_op(2'd3, 1'b1, 2'd2, 64'h4000_0000_0000_0000, '0, '0, '0, 5'd1, 8'h01, 1'b0, "R2 e64 pos");
    @(negedge clk) sat_clear = 1'b1;
    @(negedge clk) sat_clear = 1'b0;
    exp_sticky = 1'b0;
    chk(sat_sticky == 1'b0, "R8 standalone clear", 64'(sat_sticky), 64'd0);
    run_op(2'd3, 1'b1, 2'd2, 64'h8000_0000_0000_0001, '0, '0, '0, 5'd3, 8'h01, 1'b0, "R2 e64 neg");
    run_op(2'd3, 1'b0, 2'd1, 64'h0000_0000_0000_0003, '0, '0, 64'd66, '0, 8'h01, 1'b0, "R3/R5 e64");

    // Back-pressure R9
    @(negedge clk);
    out_ready = 1'b0;
    ew_sel = 2'd1; is_signed = 1'b1; shamt_src = 2'd2; shamt_imm = 5'd3;
    in_data = 64'h1234_0F00_8000_7FFF; old_data = r64(); elem_mask = 8'h0F;
    in_valid = 1'b1;
    compute(ed1, es1);
    exp_sticky = exp_sticky || (|es1);
    @(negedge clk);
    in_data = 64'h0001_0002_0003_0004;
    compute(ed2, es2);
    for (int c = 0; c < 3; c++) begin
      chk(in_ready == 1'b0, "R9 stall in_ready", 64'(in_ready), 64'd0);
      chk(out_data == ed1, "R9 stall data", out_data, ed1);
      chk(out_sat == es1, "R9 stall sat", 64'(out_sat), 64'(es1));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 second valid", 64'(out_valid), 64'd1);
    chk(out_data == ed2, "R9 second data", out_data, ed2);
    chk(sat_sticky == exp_sticky, "R8 after stall", 64'(sat_sticky), 64'(exp_sticky));
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", 64'(out_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule